// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block produces the noise voice of a sound generator. A 15-bit linear feedback shift register advances each time a programmable down-counting timer expires; the timer period is picked from a fixed, deliberately uneven 16-entry table. A mode bit chooses between two feedback taps: one gives a long hiss-like sequence, the other a short, buzzy loop.

The voice's 4-bit amplitude comes from either a constant volume or a decaying envelope. The amplitude is forced to zero when the current noise bit is low, when the length counter has run out, or when the voice is disabled. The envelope is stepped by a quarter-frame strobe and the length counter by a half-frame strobe. Both strobes come from a frame sequencer outside the block.

Software reaches the voice through three write-only registers, selected by `wr_sel`. Select 0 is envelope control, select 1 is mode and period, and select 2 is length load.

Top module: `noise_voice`

## Requirements
- R1: After reset the shift register holds 0x4000, the noise bit is 0, the length counter is 0, `amp_out` is 0 and `len_active` is 0.
- R2: On every timer tick the shift register moves right by one place, and bit 0 XOR the tap bit enters bit 14. Between ticks it holds.
- R3: The tap bit is bit 1 when bit 7 of the period register (select 1) is clear, and bit 6 when that bit is set.
- R4: On each tick the noise bit takes the inverse of shift-register bit 0 as it was before the shift. It holds until the next tick.
- R5: The timer ticks once every P clocks. P is given by bits 3:0 of select 1, indexing 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068. A new period takes effect at the next reload.
- R6: In select 0, bit 5 is halt/loop, bit 4 is constant volume and bits 3:0 are volume or envelope period. The amplitude source is the volume field when bit 4 is set, and the envelope level otherwise.
- R7: A select-2 write while enabled loads the length counter with entry bits 7:3 of the table 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30 (index 0 first). The same write restarts the envelope.
- R8: A half-frame strobe decrements a nonzero length counter unless halt is set. A load in the same cycle takes priority.
- R9: On a quarter-frame strobe, a pending restart sets the level to 15 and the divider to the period. Otherwise the divider counts down. When the divider is at 0 it reloads, and the level then decrements, or wraps to 15 if it is already 0 and loop is set.
- R10: While `chan_en` is low the length counter is cleared and length loads are ignored. `amp_out` is 0 whenever the voice is disabled, the length counter is 0 or the noise bit is 0.
- R11: `len_active` is high exactly when the length counter is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 envelope, 1 period, 2 length |
| wr_data | input | 8 | Write data |
| chan_en | input | 1 | Voice enable |
| qframe | input | 1 | Quarter-frame strobe (envelope) |
| hframe | input | 1 | Half-frame strobe (length) |
| amp_out | output | 4 | Gated amplitude |
| len_active | output | 1 | Length counter nonzero |

## Verification
The assertions check every cycle that the shift register never reaches zero and that it shifts only on a tick with the correct tap. They also check that the noise bit is the inverse of the bit shifted out, that ticks never fall on consecutive cycles, and that a disabled voice ends with an empty length counter. The bench's scenarios are needed for the timer spacing per table entry, the envelope decay and loop sequence, the length table and halt, and the load-versus-strobe priorities. It compares the ports against its own cycle model under both feedback modes.

// File: rtl/noise_voice_pkg.sv
package noise_voice_pkg;
  localparam int LFSR_W = 15;
  localparam int CNT_W  = 12;
  localparam int LEN_W  = 8;

  localparam logic [1:0] SEL_ENV = 2'd0;
  localparam logic [1:0] SEL_PER = 2'd1;
  localparam logic [1:0] SEL_LEN = 2'd2;

  function automatic logic [CNT_W-1:0] period_of(input logic [3:0] idx);
    case (idx)
      4'd0:  period_of = 12'd4;
      4'd1:  period_of = 12'd8;
      4'd2:  period_of = 12'd16;
      4'd3:  period_of = 12'd32;
      4'd4:  period_of = 12'd64;
      4'd5:  period_of = 12'd96;
      4'd6:  period_of = 12'd128;
      4'd7:  period_of = 12'd160;
      4'd8:  period_of = 12'd202;
      4'd9:  period_of = 12'd254;
      4'd10: period_of = 12'd380;
      4'd11: period_of = 12'd508;
      4'd12: period_of = 12'd762;
      4'd13: period_of = 12'd1016;
      4'd14: period_of = 12'd2034;
      default: period_of = 12'd4068;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] length_of(input logic [4:0] idx);
    if (idx[0]) begin
      length_of = (idx == 5'd1) ? 8'd254 : {3'd0, idx} - 8'd1;
    end else begin
      case (idx[4:1])
        4'd0:  length_of = 8'd10;
        4'd1:  length_of = 8'd20;
        4'd2:  length_of = 8'd40;
        4'd3:  length_of = 8'd80;
        4'd4:  length_of = 8'd160;
        4'd5:  length_of = 8'd60;
        4'd6:  length_of = 8'd14;
        4'd7:  length_of = 8'd26;
        4'd8:  length_of = 8'd12;
        4'd9:  length_of = 8'd24;
        4'd10: length_of = 8'd48;
        4'd11: length_of = 8'd96;
        4'd12: length_of = 8'd192;
        4'd13: length_of = 8'd72;
        4'd14: length_of = 8'd16;
        default: length_of = 8'd32;
      endcase
    end
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                   input logic short_mode);
    logic fb;
    fb = s[0] ^ (short_mode ? s[6] : s[1]);
    lfsr_step = {fb, s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/noise_timer.sv
module noise_timer
  import noise_voice_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] per_idx,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= period_of(per_idx) - 1'b1;
    else           cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_voice_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 15'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              short_mode,
  output logic [LFSR_W-1:0] state,
  output logic              noise_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEED;
      noise_bit <= 1'b0;
    end else if (tick) begin
      state     <= lfsr_step(state, short_mode);
      noise_bit <= ~state[0];
    end
  end
endmodule

// File: rtl/noise_envelope.sv
module noise_envelope (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       qframe,
  input  logic       loop_en,
  input  logic [3:0] period,
  output logic [3:0] level
);
  logic       start_q;
  logic [3:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      div_q   <= '0;
      level   <= '0;
    end else begin
      if (qframe) begin
        if (start_q) begin
          start_q <= 1'b0;
          level   <= 4'd15;
          div_q   <= period;
        end else if (div_q == '0) begin
          div_q <= period;
          if (level != '0) level <= level - 1'b1;
          else if (loop_en) level <= 4'd15;
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
      if (restart) start_q <= 1'b1;
    end
  end
endmodule

// File: rtl/noise_voice.sv
module noise_voice
  import noise_voice_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       chan_en,
  input  logic       qframe,
  input  logic       hframe,
  output logic [3:0] amp_out,
  output logic       len_active
);
  logic              halt_loop, const_vol, short_mode;
  logic [3:0]        vol_per, per_idx;
  logic [LEN_W-1:0]  len_q;
  logic              tick, noise_bit, len_load;
  logic [LFSR_W-1:0] lfsr_q;
  logic [3:0]        env_level;

  assign len_load = wr_en && (wr_sel == SEL_LEN) && chan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_loop  <= 1'b0;
      const_vol  <= 1'b0;
      vol_per    <= '0;
      short_mode <= 1'b0;
      per_idx    <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_ENV) begin
        halt_loop <= wr_data[5];
        const_vol <= wr_data[4];
        vol_per   <= wr_data[3:0];
      end else if (wr_sel == SEL_PER) begin
        short_mode <= wr_data[7];
        per_idx    <= wr_data[3:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              len_q <= '0;
    else if (!chan_en)                       len_q <= '0;
    else if (len_load)                       len_q <= length_of(wr_data[7:3]);
    else if (hframe && !halt_loop && len_q != '0) len_q <= len_q - 1'b1;
  end

  noise_timer u_timer (
    .clk(clk), .rst_n(rst_n), .per_idx(per_idx), .tick(tick)
  );

  noise_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .short_mode(short_mode),
    .state(lfsr_q), .noise_bit(noise_bit)
  );

  noise_envelope u_env (
    .clk(clk), .rst_n(rst_n), .restart(len_load), .qframe(qframe),
    .loop_en(halt_loop), .period(vol_per), .level(env_level)
  );

  assign len_active = (len_q != '0);
  assign amp_out = (chan_en && len_active && noise_bit)
                   ? (const_vol ? vol_per : env_level) : 4'd0;
endmodule

// File: rtl/noise_voice_chk.sv
module noise_voice_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chan_en,
  input logic        tick,
  input logic        short_mode,
  input logic [14:0] lfsr_q,
  input logic        noise_bit,
  input logic        len_active
);
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);                                                       // R2
  AST_SHIFT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lfsr_q[13:0] == $past(lfsr_q[14:1]));                       // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lfsr_q));                                          // R2
  AST_TAP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lfsr_q[14] == ($past(lfsr_q[0]) ^
      ($past(short_mode) ? $past(lfsr_q[6]) : $past(lfsr_q[1]))));       // R3
  AST_BIT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> noise_bit == !$past(lfsr_q[0]));                            // R4
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);                                                     // R5
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !len_active);                                           // R10
endmodule

bind noise_voice noise_voice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick(tick),
  .short_mode(short_mode), .lfsr_q(lfsr_q), .noise_bit(noise_bit),
  .len_active(len_active)
);

// File: tb/noise_voice_bench.sv
module noise_voice_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       chan_en = 1'b0;
  logic       qframe = 1'b0;
  logic       hframe = 1'b0;
  logic [3:0] amp_out;
  logic       len_active;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit cmp_on  = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  noise_voice u_noise_voice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .chan_en(chan_en), .qframe(qframe), .hframe(hframe),
    .amp_out(amp_out), .len_active(len_active)
  );

  function automatic int b_period(input int i);
    int t[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508,
                  762, 1016, 2034, 4068};
    return t[i];
  endfunction

  function automatic int b_length(input int i);
    int t[32] = '{10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14,
                  12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30};
    return t[i];
  endfunction

  // reference model, built from the requirements
  int m_cnt, m_len, m_level, m_div, m_vol, m_idx;
  bit m_halt, m_const, m_short, m_start, m_bit;
  bit [14:0] m_sr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_len = 0; m_level = 0; m_div = 0; m_vol = 0; m_idx = 0;
      m_halt = 0; m_const = 0; m_short = 0; m_start = 0; m_bit = 0;
      m_sr = 15'h4000;
    end else begin
      bit load;
      bit [14:0] old;
      load = wr_en && wr_sel == 2'd2 && chan_en;
      // length (R7, R8, R10)
      if (!chan_en) m_len = 0;
      else if (load) m_len = b_length(int'(wr_data[7:3]));
      else if (hframe && !m_halt && m_len > 0) m_len = m_len - 1;
      // envelope (R9)
      if (qframe) begin
        if (m_start) begin m_start = 0; m_level = 15; m_div = m_vol; end
        else if (m_div == 0) begin
          m_div = m_vol;
          if (m_level > 0) m_level = m_level - 1;
          else if (m_halt) m_level = 15;
        end else m_div = m_div - 1;
      end
      if (load) m_start = 1;
      // timer and shift register (R2-R5)
      if (m_cnt == 0) begin
        old = m_sr;
        m_sr = old >> 1;
        m_sr[14] = old[0] ^ (m_short ? old[6] : old[1]);
        m_bit = !old[0];
        m_cnt = b_period(m_idx) - 1;
      end else m_cnt = m_cnt - 1;
      // register writes
      if (wr_en && wr_sel == 2'd0) begin
        m_halt = wr_data[5]; m_const = wr_data[4]; m_vol = int'(wr_data[3:0]);
      end
      if (wr_en && wr_sel == 2'd1) begin
        m_short = wr_data[7]; m_idx = int'(wr_data[3:0]);
      end
    end
  end

  function automatic int exp_amp();
    if (!chan_en || m_len == 0 || !m_bit) return 0;
    return m_const ? m_vol : m_level;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check({phase, " amp"}, int'(amp_out), exp_amp());
      check("R11 len_active", int'(len_active), int'(m_len != 0));
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int qprob, input int hprob, input int wprob);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      qframe = ($urandom % qprob) == 0;
      hframe = ($urandom % hprob) == 0;
      wr_en  = ($urandom % wprob) == 0;
      wr_sel = 2'd2;
      wr_data = 8'($urandom);
    end
    @(negedge clk);
    qframe = 1'b0; hframe = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 amp", int'(amp_out), 0);
    check("R1 len_active", int'(len_active), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R2/R4: long mode, fastest period, constant full volume
    phase = "R2";
    chan_en = 1'b1;
    wr(2'd0, 8'h3F);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h08);
    run(3000, 100000, 100000, 100000);

    // R3: short mode
    phase = "R3";
    wr(2'd1, 8'h81);
    run(3000, 100000, 100000, 100000);

    // R5: sweep through every period entry
    phase = "R5";
    for (int p = 0; p < 16; p++) begin
      wr(2'd1, 8'(p) | ((p % 3 == 0) ? 8'h80 : 8'h00));
      run(p < 12 ? 1500 : 4500, 100000, 100000, 100000);
    end

    // R6/R9: envelope decay with loop, then without loop
    phase = "R9";
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h22);
    wr(2'd2, 8'h00);
    run(4000, 8, 100000, 100000);
    phase = "R6";
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h08);
    run(3000, 6, 100000, 100000);

    // R8: halt freezes length, clear lets it run down
    phase = "R8";
    wr(2'd0, 8'h3A);
    wr(2'd2, 8'h18);
    run(600, 100000, 4, 100000);
    check("R8 halted length held", int'(len_active), 1);
    wr(2'd0, 8'h1A);
    wr(2'd2, 8'h18);   // index 3 -> 2
    run(200, 100000, 3, 100000);
    check("R8 length ran out", int'(len_active), 0);

    // R7: write while enabled loads table entry; random loads
    phase = "R7";
    wr(2'd2, 8'h20);   // index 4 -> 40
    check("R7 load", int'(len_active), 1);
    run(6000, 10, 20, 40);

    // R10: disable clears and ignores loads
    phase = "R10";
    @(negedge clk); chan_en = 1'b0;
    @(negedge clk);
    check("R10 disabled length", int'(len_active), 0);
    wr(2'd2, 8'hF8);
    check("R10 ignored load", int'(len_active), 0);
    @(negedge clk); chan_en = 1'b1;
    @(negedge clk);
    check("R10 enable alone loads nothing", int'(len_active), 0);

    // mixed random traffic across all registers
    phase = "R10 random";
    for (int k = 0; k < 40; k++) begin
      wr(2'($urandom % 3), 8'($urandom));
      chan_en = ($urandom % 8) != 0;
      run(300, 12, 24, 60);
    end

    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule